// File: doc/BRIEF.md
# Serial Display Link Decoder

This block terminates the host side of a four-wire serial link that configures a segment display controller and reaches its display memory. The link has an active-low select, a write strobe, a read strobe and one data line that the host drives on writes and the block drives on reads. All four pins come in asynchronously. They are resampled on a fast system clock, and strobe edges are found from the resampled levels.

A frame opens when select falls. Three mode bits come first. The command mode then takes a chain of nine-bit command words. The two data modes take a six-bit start address and then a run of four-bit memory units. The block issues a one-cycle write to an external display memory. It reads that memory through an address output and a combinational data input. It raises a one-cycle command strobe carrying the opcode. During reads it drives the data line through an output enable. The write mode also accepts read strobes, so each unit can be read back before it is overwritten in place. Display scanning and analog drive belong to other blocks.

Top module: `segif_link`

## Requirements
- R1: While select (`sel_n`) is high, strobes and data have no effect. The decoder returns to waiting for a mode code, any partial word is cleared and `sdio_oe` goes low. After reset no write, command or drive is active.
- R2: The first three bits after select falls form the mode code, sent MSB first. 100 selects command mode, 101 selects write mode and 110 selects read mode. Any other code causes the rest of the frame to be discarded.
- R3: In both data modes, a six-bit start address follows the mode code, MSB first. Memory addresses run from 0 to 63 and wrap from 63 to 0.
- R4: `sdio_in` is sampled on each rising `wstb_n` edge. Each pin passes through two synchronizer flops. A pin change made between clock edges takes effect at the third rising clock edge after it.
- R5: A command word is nine bits long. The first eight bits are the opcode, MSB first, and the ninth bit is ignored. When the ninth bit is taken, `cmd_valid` pulses for one cycle with `cmd_op`.
- R6: After a single 100 code, any number of command words may follow in the same frame.
- R7: In write mode, every four bits form one unit, MSB first. The unit causes a one-cycle `mem_we` with the current address, and then the address advances by one.
- R8: In the data modes, each falling `rstb_n` loads one bit of the unit at the current address into the output register, MSB first. The bit is driven while `sdio_oe` is high, which holds from the next rising `rstb_n` to the following falling one. In read mode the address advances after every four falling edges.
- R9: In write mode, falling `rstb_n` edges read bits of the unit at the current address without advancing it. Only the completed written unit advances the address.
- R10: A rising write strobe seen while the read strobe is low is ignored. A falling read strobe seen while the write strobe is low is ignored.
- R11: When select rises part-way through a word, the partial word is discarded. No memory write and no command strobe results, even if select rises in the same cycle as the final write strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Frame select, active low |
| wstb_n | input | 1 | Write strobe; data is taken on its rising edge |
| rstb_n | input | 1 | Read strobe; a bit is loaded on its falling edge |
| sdio_in | input | 1 | Data line as received |
| sdio_out | output | 1 | Data line value driven during reads |
| sdio_oe | output | 1 | Output enable for the data line |
| mem_we | output | 1 | One-cycle display memory write |
| mem_waddr | output | 6 | Write address |
| mem_wdata | output | 4 | Write unit |
| mem_raddr | output | 6 | Read address to the memory |
| mem_rdata | input | 4 | Unit at `mem_raddr`, combinational |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_op | output | 8 | Opcode of the command |

## Verification
The close of a frame and the completion of a word can land in the same clock. This happens when select and the final write strobe rise together, and select must then win so that nothing is written. The bench provokes this by releasing both pins on one clock and judges it two ways: the reference model expects no write pulse, and the memory location must be unchanged afterwards. A second collision, in which both strobes are held low with a write rising over a low read, is judged by the alignment of the unit that follows.

// File: rtl/segif_pkg.sv
package segif_pkg;

    localparam int ADDR_W      = 6;
    localparam int UNIT_W      = 4;
    localparam int OP_W        = 8;
    localparam int MODE_W      = 3;
    localparam int SYNC_STAGES = 2;

    localparam logic [MODE_W-1:0] MODE_CMD = 3'b100;
    localparam logic [MODE_W-1:0] MODE_WR  = 3'b101;
    localparam logic [MODE_W-1:0] MODE_RD  = 3'b110;

    typedef enum logic [2:0] {
        ST_MODE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_DROP
    } dec_state_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic din;
    } pin_lvl_t;

    function automatic logic is_data_state(dec_state_e s);
        return (s == ST_WDATA) || (s == ST_RDATA);
    endfunction

endpackage

// File: rtl/segif_sync.sv
module segif_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o
);
    logic [STAGES-1:0][W-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], pin_i};
            end
        end
    endgenerate

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/segif_decoder.sv
module segif_decoder
    import segif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_lvl_t          pins,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [UNIT_W-1:0] mem_wdata,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              rd_take,
    output logic              rd_drive,
    output logic [$clog2(UNIT_W)-1:0] rd_bit
);
    localparam int CNT_W = $clog2(OP_W + 1);
    localparam int RC_W  = $clog2(UNIT_W);

    dec_state_e        st;
    logic              wmode;
    logic [CNT_W-1:0]  cnt;
    logic [OP_W-1:0]   sh;
    logic [ADDR_W-1:0] addr;
    logic [RC_W-1:0]   rc;
    logic              wr_prev, rd_prev;
    logic              wr_rise, rd_fall, rd_rise, wr_take;

    assign wr_rise  = pins.wr & ~wr_prev;
    assign rd_fall  = ~pins.rd & rd_prev;
    assign rd_rise  = pins.rd & ~rd_prev;
    assign wr_take  = wr_rise & pins.rd & ~pins.sel;
    assign rd_take  = rd_fall & pins.wr & ~pins.sel & is_data_state(st);
    assign rd_drive = rd_rise & pins.wr & ~pins.sel & is_data_state(st);
    assign cur_addr = addr;
    assign rd_bit   = rc;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b1;
            rd_prev <= 1'b1;
        end else begin
            wr_prev <= pins.wr;
            rd_prev <= pins.rd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_MODE;
            wmode     <= 1'b0;
            cnt       <= '0;
            sh        <= '0;
            addr      <= '0;
            rc        <= '0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= '0;
        end else begin
            mem_we    <= 1'b0;
            cmd_valid <= 1'b0;
            if (pins.sel) begin
                st  <= ST_MODE;
                cnt <= '0;
                sh  <= '0;
                rc  <= '0;
            end else begin
                if (wr_take) begin
                    case (st)
                        ST_MODE: begin
                            if (cnt == CNT_W'(MODE_W - 1)) begin
                                cnt <= '0;
                                case ({sh[MODE_W-2:0], pins.din})
                                    MODE_CMD: st <= ST_CMD;
                                    MODE_WR: begin
                                        st    <= ST_ADDR;
                                        wmode <= 1'b1;
                                    end
                                    MODE_RD: begin
                                        st    <= ST_ADDR;
                                        wmode <= 1'b0;
                                    end
                                    default: st <= ST_DROP;
                                endcase
                            end else begin
                                sh  <= {sh[OP_W-2:0], pins.din};
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_ADDR: begin
                            addr <= {addr[ADDR_W-2:0], pins.din};
                            if (cnt == CNT_W'(ADDR_W - 1)) begin
                                cnt <= '0;
                                rc  <= '0;
                                st  <= wmode ? ST_WDATA : ST_RDATA;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_CMD: begin
                            if (cnt == CNT_W'(OP_W)) begin
                                cmd_valid <= 1'b1;
                                cmd_op    <= sh;
                                cnt       <= '0;
                            end else begin
                                sh  <= {sh[OP_W-2:0], pins.din};
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            if (cnt == CNT_W'(UNIT_W - 1)) begin
                                mem_we    <= 1'b1;
                                mem_waddr <= addr;
                                mem_wdata <= {sh[UNIT_W-2:0], pins.din};
                                addr      <= addr + 1'b1;
                                cnt       <= '0;
                                rc        <= '0;
                            end else begin
                                sh  <= {sh[OP_W-2:0], pins.din};
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (rd_take) begin
                    if (rc == RC_W'(UNIT_W - 1)) begin
                        rc <= '0;
                        if (st == ST_RDATA) addr <= addr + 1'b1;
                    end else begin
                        rc <= rc + 1'b1;
                    end
                end
            end
        end
    end

    // R5: a command strobe only ever leaves the command state
    assert_cmd_from_cmd_state_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(st == ST_CMD));
    // R7: memory writes only come out of the write-mode data phase
    assert_write_from_wdata_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(st == ST_WDATA));
    // R11: a deselected frame yields neither write nor command
    assert_no_issue_after_sel_R11: assert property (@(posedge clk) disable iff (rst)
        pins.sel |=> (!mem_we && !cmd_valid));
    // R6: command and memory write never share a cycle
    assert_write_cmd_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && cmd_valid));
endmodule

// File: rtl/segif_readout.sv
module segif_readout
    import segif_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sel,
    input  logic                      rd_take,
    input  logic                      rd_drive,
    input  logic [$clog2(UNIT_W)-1:0] rd_bit,
    input  logic [UNIT_W-1:0]         unit_i,
    output logic                      out_o,
    output logic                      oe_o
);
    localparam int RC_W = $clog2(UNIT_W);

    logic [RC_W-1:0] idx;
    assign idx = RC_W'(UNIT_W - 1) - rd_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= 1'b0;
            oe_o  <= 1'b0;
        end else begin
            if (rd_take) out_o <= unit_i[idx];
            if (sel || rd_take) oe_o <= 1'b0;
            else if (rd_drive)  oe_o <= 1'b1;
        end
    end

    // R1: deselect releases the data line on the next cycle
    assert_oe_released_R1: assert property (@(posedge clk) disable iff (rst)
        sel |=> !oe_o);
    // R8: the line is only turned on by a read strobe rising edge
    assert_oe_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_o) |-> $past(rd_drive));
    // R8: a new bit load always turns the driver off for that strobe
    assert_oe_off_on_load_R8: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> !oe_o);
endmodule

// File: rtl/segif_link.sv
module segif_link
    import segif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wstb_n,
    input  logic              rstb_n,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [UNIT_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [UNIT_W-1:0] mem_rdata,
    output logic              cmd_valid,
    output logic [OP_W-1:0]   cmd_op
);
    localparam int RC_W = $clog2(UNIT_W);

    pin_lvl_t        raw, lvl;
    logic            rd_take, rd_drive;
    logic [RC_W-1:0] rd_bit;

    assign raw = '{sel: sel_n, wr: wstb_n, rd: rstb_n, din: sdio_in};

    segif_sync #(
        .W       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1110)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (raw),
        .lvl_o (lvl)
    );

    segif_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .pins      (lvl),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cur_addr  (mem_raddr),
        .rd_take   (rd_take),
        .rd_drive  (rd_drive),
        .rd_bit    (rd_bit)
    );

    segif_readout u_rdo (
        .clk      (clk),
        .rst      (rst),
        .sel      (lvl.sel),
        .rd_take  (rd_take),
        .rd_drive (rd_drive),
        .rd_bit   (rd_bit),
        .unit_i   (mem_rdata),
        .out_o    (sdio_out),
        .oe_o     (sdio_oe)
    );
endmodule

// File: tb/segif_link_test.sv
`timescale 1ns/1ps
module segif_link_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, wstb_n = 1'b1, rstb_n = 1'b1, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, mem_we, cmd_valid;
    logic [5:0] mem_waddr, mem_raddr;
    logic [3:0] mem_wdata, mem_rdata;
    logic [7:0] cmd_op;

    int tests = 0, fails = 0, we_count = 0;
    bit done = 0;
    logic [3:0] mem [64];
    int cmd_log [$];

    always #2 clk = ~clk;

    segif_link uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wstb_n(wstb_n), .rstb_n(rstb_n),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op)
    );

    function automatic int init_val(int i);
        return (i * 5 + 3) % 16;
    endfunction

    assign mem_rdata = mem[mem_raddr];

    initial for (int i = 0; i < 64; i++) mem[i] = 4'(init_val(i));
    always @(posedge clk) if (!rst && mem_we) mem[mem_waddr] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: pins seen one and two edges back (R4 latency)
    int h0[4], h1[4], h2[4];       // index 0 sel,1 wr,2 rd,3 din
    int m_st, m_cnt, m_acc, m_addr, m_rc, m_wmode;
    int e_we, e_waddr, e_wdata, e_cv, e_op, e_oe, e_out;
    int mm [64];

    initial for (int i = 0; i < 64; i++) mm[i] = init_val(i);

    always @(posedge clk) begin
        if (rst) begin
            h0 = '{1,1,1,0}; h1 = '{1,1,1,0}; h2 = '{1,1,1,0};
            m_st = 0; m_cnt = 0; m_acc = 0; m_addr = 0; m_rc = 0; m_wmode = 0;
            e_we = 0; e_cv = 0; e_oe = 0; e_out = 0; e_waddr = 0; e_wdata = 0; e_op = 0;
        end else begin
            bit wr_r, rd_f, rd_r, dstate;
            e_we = 0; e_cv = 0;
            wr_r = (h1[1] == 1) && (h2[1] == 0);
            rd_f = (h1[2] == 0) && (h2[2] == 1);
            rd_r = (h1[2] == 1) && (h2[2] == 0);
            dstate = (m_st == 3) || (m_st == 4);
            if (h1[0] == 1) begin
                m_st = 0; m_cnt = 0; m_acc = 0; m_rc = 0; e_oe = 0;
            end else begin
                if (rd_f && h1[1] == 1 && dstate) begin
                    e_out = (mm[m_addr] >> (3 - m_rc)) & 1;
                    e_oe = 0;
                    m_rc++;
                    if (m_rc == 4) begin
                        m_rc = 0;
                        if (m_st == 4) m_addr = (m_addr + 1) % 64;
                    end
                end else if (rd_r && h1[1] == 1 && dstate) e_oe = 1;
                if (wr_r && h1[2] == 1) begin
                    int b;
                    b = h1[3];
                    case (m_st)
                        0: begin
                            m_acc = m_acc * 2 + b; m_cnt++;
                            if (m_cnt == 3) begin
                                if (m_acc == 4) m_st = 2;
                                else if (m_acc == 5) begin m_st = 1; m_wmode = 1; end
                                else if (m_acc == 6) begin m_st = 1; m_wmode = 0; end
                                else m_st = 5;
                                m_cnt = 0; m_acc = 0;
                            end
                        end
                        1: begin
                            m_addr = (m_addr * 2 + b) % 64; m_cnt++;
                            if (m_cnt == 6) begin m_cnt = 0; m_rc = 0; m_st = m_wmode ? 3 : 4; end
                        end
                        2: begin
                            if (m_cnt == 8) begin e_cv = 1; e_op = m_acc; m_cnt = 0; m_acc = 0; end
                            else begin m_acc = (m_acc * 2 + b) % 256; m_cnt++; end
                        end
                        3: begin
                            m_acc = (m_acc * 2 + b) % 16; m_cnt++;
                            if (m_cnt == 4) begin
                                e_we = 1; e_waddr = m_addr; e_wdata = m_acc; mm[m_addr] = m_acc;
                                m_addr = (m_addr + 1) % 64; m_cnt = 0; m_acc = 0; m_rc = 0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            h2 = h1; h1 = h0;
            h0 = '{int'(sel_n), int'(wstb_n), int'(rstb_n), int'(sdio_in)};
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(int'(mem_we) == e_we, "R7 R4 write strobe", int'(mem_we), e_we);
            if (e_we == 1 && mem_we) begin
                chk(int'(mem_waddr) == e_waddr, "R3 R7 write address", int'(mem_waddr), e_waddr);
                chk(int'(mem_wdata) == e_wdata, "R7 write unit", int'(mem_wdata), e_wdata);
            end
            chk(int'(cmd_valid) == e_cv, "R5 R4 command strobe", int'(cmd_valid), e_cv);
            if (e_cv == 1 && cmd_valid)
                chk(int'(cmd_op) == e_op, "R5 opcode", int'(cmd_op), e_op);
            chk(int'(sdio_oe) == e_oe, "R8 R1 output enable", int'(sdio_oe), e_oe);
            if (e_oe == 1 && sdio_oe)
                chk(int'(sdio_out) == e_out, "R8 driven bit", int'(sdio_out), e_out);
            if (mem_we) we_count++;
            if (cmd_valid) cmd_log.push_back(int'(cmd_op));
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wbit(input int b);
        sdio_in = 1'(b); wstb_n = 1'b0; hold(4); wstb_n = 1'b1; hold(4);
    endtask
    task automatic wbits(input int v, input int n);
        for (int i = n - 1; i >= 0; i--) wbit((v >> i) & 1);
    endtask
    task automatic rbit(output int b);
        rstb_n = 1'b0; hold(4); rstb_n = 1'b1; hold(4);
        b = sdio_oe ? int'(sdio_out) : -1;
    endtask
    task automatic rbits(input int n, output int v);
        v = 0;
        for (int i = 0; i < n; i++) begin
            int b;
            rbit(b);
            v = v * 2 + b;
        end
    endtask
    task automatic fstart; sel_n = 1'b0; hold(4); endtask
    task automatic fend;   sel_n = 1'b1; hold(4); endtask

    initial begin
        int v, wc;
        hold(3);
        rst = 1'b0;
        hold(1);
        // R1: reset state
        chk(sdio_oe == 1'b0 && mem_we == 1'b0 && cmd_valid == 1'b0, "R1 reset outputs",
            int'({sdio_oe, mem_we, cmd_valid}), 0);

        // R5 R6: chained commands under one prefix
        fstart; wbits(3'b100, 3);
        wbits(8'h2A, 8); wbit(1);
        wbits(8'hC3, 8); wbit(0);
        wbits(8'h01, 8); wbit(1);
        fend;
        chk(cmd_log.size() == 3, "R6 command count", cmd_log.size(), 3);
        if (cmd_log.size() == 3) begin
            chk(cmd_log[0] == 'h2A, "R5 first opcode", cmd_log[0], 'h2A);
            chk(cmd_log[2] == 'h01, "R6 third opcode", cmd_log[2], 'h01);
        end

        // R3 R7: write three units from 62, wrapping to 0
        fstart; wbits(3'b101, 3); wbits(62, 6);
        wbits(4'h9, 4); wbits(4'h3, 4); wbits(4'hE, 4);
        fend;
        chk(mem[62] == 4'h9, "R7 unit at 62", int'(mem[62]), 9);
        chk(mem[63] == 4'h3, "R7 unit at 63", int'(mem[63]), 3);
        chk(mem[0] == 4'hE, "R3 wrap to 0", int'(mem[0]), 14);

        // R8: read back two units
        fstart; wbits(3'b110, 3); wbits(62, 6);
        rbits(4, v); chk(v == 9, "R8 read unit 62", v, 9);
        rbits(4, v); chk(v == 3, "R8 read unit 63 after advance", v, 3);
        fend;

        // R9: read then overwrite in write mode
        fstart; wbits(3'b101, 3); wbits(10, 6);
        rbits(4, v); chk(v == init_val(10), "R9 read before write", v, init_val(10));
        wbits(4'h6, 4);
        rbits(4, v); chk(v == init_val(11), "R9 next unit after write", v, init_val(11));
        wbits(4'hB, 4);
        fend;
        chk(mem[10] == 4'h6, "R9 overwrite 10", int'(mem[10]), 6);
        chk(mem[11] == 4'hB, "R9 overwrite 11", int'(mem[11]), 11);

        // R2: unknown mode codes drop the frame
        wc = we_count;
        fstart; wbits(3'b111, 3); wbits(5, 6); wbits(4'h1, 4); fend;
        fstart; wbits(3'b000, 3); wbits(8'hFF, 8); wbit(0); fend;
        chk(we_count == wc, "R2 no write on bad mode", we_count, wc);
        chk(cmd_log.size() == 3, "R2 no command on bad mode", cmd_log.size(), 3);

        // R11: partial unit and partial command; final edge together with select
        fstart; wbits(3'b101, 3); wbits(20, 6); wbits(2'b11, 2); fend;
        fstart; wbits(3'b101, 3); wbits(21, 6); wbits(3'b101, 3);
        sdio_in = 1'b0; wstb_n = 1'b0; hold(4);
        wstb_n = 1'b1; sel_n = 1'b1; hold(8);
        fstart; wbits(3'b100, 3); wbits(5'h1F, 5); fend;
        chk(mem[20] == 4'(init_val(20)), "R11 partial unit dropped", int'(mem[20]), init_val(20));
        chk(mem[21] == 4'(init_val(21)), "R11 select with last edge", int'(mem[21]), init_val(21));
        chk(we_count == wc, "R11 no write strobe", we_count, wc);
        chk(cmd_log.size() == 3, "R11 no command strobe", cmd_log.size(), 3);

        // R10: overlapped strobes are ignored
        fstart; wbits(3'b101, 3); wbits(30, 6);
        sdio_in = 1'b1; wstb_n = 1'b0; hold(4);
        rstb_n = 1'b0; hold(4);
        wstb_n = 1'b1; hold(4);
        rstb_n = 1'b1; hold(4);
        wbits(4'h5, 4);
        fend;
        chk(mem[30] == 4'h5, "R10 overlap ignored", int'(mem[30]), 5);

        // R1: strobes while deselected do nothing
        wc = we_count;
        wbits(3'b100, 3); wbits(8'h77, 8); wbit(0);
        chk(cmd_log.size() == 3, "R1 no command while deselected", cmd_log.size(), 3);
        fstart; wbits(3'b101, 3); wbits(40, 6); wbits(4'h7, 4); fend;
        chk(mem[40] == 4'h7, "R1 fresh frame decodes", int'(mem[40]), 7);
        chk(we_count == wc + 1, "R1 single write", we_count, wc + 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule